// File: doc/BRIEF.md
# Frame-Synchronized Pixel Signature Capture

This block sits on the pixel input path of a display pipeline. It conditions each incoming 64-bit pixel word and folds the conditioned words into a 32-bit multiple-input signature register. Conditioning has two steps. A width control either keeps the full word or keeps only the low 32 bits. A mask control can then AND the word with a pair of 32-bit mask words. When the alternate (VGA) port is selected, the word passes through unchanged.

Signature capture is tied to frame boundaries. A frame starts on the falling edge of the vertical-blanking input, sampled in the pixel clock domain. Changes to the capture enable take effect only at that edge:
- Turning the enable on clears the signature at the next frame start and begins accumulation there.
- Turning it off lets the current frame finish; accumulation then stops at the next frame start and the value is held.

A run flag tells software when a complete frame signature is available.

Top module: `pix_sig_capture`

## Requirements
- R1: While rst_ni is low, sig_o is 0 and sig_run_o is 0.
- R2: With vga_sel_i=0 and wide_i=0, pix_o[63:32] is 0 and pix_o[31:0] is pix_i[31:0] (ANDed with mask_lo_i when mask_en_i=1).
- R3: With vga_sel_i=0 and wide_i=1, all 64 bits of pix_i reach pix_o (masked when mask_en_i=1).
- R4: With vga_sel_i=0 and mask_en_i=1, pix_o is the width-selected word ANDed bitwise with {mask_hi_i, mask_lo_i}; mask_hi_i covers bits 63:32.
- R5: With vga_sel_i=1, pix_o equals pix_i, whatever the values of mask_en_i and wide_i.
- R6: A frame start is a cycle in which vblank_i is 0 and its value sampled at the previous clock edge was 1. The register reset for that previous sample holds 0. sig_run_o and sig_o change at no other edge except through accumulation while running.
- R7: At a frame start with sig_en_i=1 and sig_run_o=0, the signature restarts from 0. A valid pixel in that same cycle is already accumulated.
- R8: While accumulation is active, each cycle with pix_valid_i=1 replaces the signature s with ((s<<1) XOR (s[31] ? 32'h0040_0007 : 0)) XOR pix_o[63:32] XOR pix_o[31:0]. The constant 32'h0040_0007 is the polynomial x^32+x^22+x^2+x+1. Cycles with pix_valid_i=0 leave the signature unchanged.
- R9: Clearing sig_en_i mid-frame does not stop accumulation until the next frame start. From that frame start onward (including its own cycle), the signature holds.
- R10: At every frame start, sig_run_o takes the value of sig_en_i, registered at that edge.
- R11: With sig_en_i held at 1 across a frame start while running, the signature is not cleared and accumulation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_i | input | 64 | Raw pixel word |
| pix_valid_i | input | 1 | Pixel word valid strobe |
| vblank_i | input | 1 | Vertical blanking indicator |
| vga_sel_i | input | 1 | Alternate port selected; bypasses conditioning |
| sig_en_i | input | 1 | Signature capture enable |
| mask_en_i | input | 1 | Pixel masking enable |
| wide_i | input | 1 | 1: 64-bit word, 0: 32-bit word |
| mask_hi_i | input | 32 | Mask for pixel bits 63:32 |
| mask_lo_i | input | 32 | Mask for pixel bits 31:0 |
| pix_o | output | 64 | Conditioned pixel word |
| sig_o | output | 32 | Current signature |
| sig_run_o | output | 1 | Signature accumulation active |

## Verification
The bench builds the block with its default parameters: 32-bit lanes, two lanes, and the x^32+x^22+x^2+x+1 taps. These reach every conditioning combination and the feedback path through bit 31. Random pixel data and a random valid strobe drive several frames through the following sequence:
- an enable raised mid-frame that must wait for the edge;
- a start edge that may carry a valid pixel;
- a frame boundary crossed while running;
- an enable dropped mid-frame, after which the signature must keep moving until the next edge and then freeze.

// File: rtl/pix_sig_pkg.sv
package pix_sig_pkg;
  localparam int unsigned LANE_W_DEF = 32;
  localparam logic [31:0] TAPS_DEF   = 32'h0040_0007;
endpackage

// File: rtl/pix_cond.sv
module pix_cond #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 2,
  localparam int unsigned PIX_W = LANE_W * LANES
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] mask_i,
  input  logic             vga_sel_i,
  input  logic             mask_en_i,
  input  logic             wide_i,
  output logic [PIX_W-1:0] pix_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              lane_on;
    logic [LANE_W-1:0] lane_msk;
    // lane 0 is always used; upper lanes only in wide mode or bypass
    if (g == 0) begin : g_base
      assign lane_on = 1'b1;
    end else begin : g_upper
      assign lane_on = wide_i | vga_sel_i;
    end
    assign lane_msk = (mask_en_i && !vga_sel_i) ? mask_i[g*LANE_W +: LANE_W] : '1;
    assign pix_o[g*LANE_W +: LANE_W] = lane_on ? (pix_i[g*LANE_W +: LANE_W] & lane_msk) : '0;
  end
endmodule

// File: rtl/frame_edge.sv
module frame_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  output logic frame_start_o
);
  logic vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end

  assign frame_start_o = vb_q & ~vblank_i;
endmodule

// File: rtl/misr_core.sv
module misr_core #(
  parameter int unsigned        W     = 32,
  parameter int unsigned        LANES = 2,
  parameter logic [W-1:0]       TAPS  = 32'h0040_0007,
  localparam int unsigned       IN_W  = W * LANES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic            en_i,
  input  logic            valid_i,
  input  logic [IN_W-1:0] data_i,
  output logic [W-1:0]    sig_o,
  output logic            run_o
);
  logic [W-1:0] sig_q, base, fold, sig_d;
  logic         run_q, run_d, restart;

  always_comb begin
    fold = '0;
    for (int i = 0; i < LANES; i++) fold ^= data_i[i*W +: W];
  end

  assign run_d   = frame_start_i ? en_i : run_q;
  assign restart = frame_start_i & en_i & ~run_q;
  assign base    = restart ? '0 : sig_q;

  always_comb begin
    sig_d = base;
    if (run_d && valid_i)
      sig_d = {base[W-2:0], 1'b0} ^ (base[W-1] ? TAPS : '0) ^ fold;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= '0;
      run_q <= 1'b0;
    end else begin
      sig_q <= sig_d;
      run_q <= run_d;
    end
  end

  assign sig_o = sig_q;
  assign run_o = run_q;
endmodule

// File: rtl/pix_sig_capture.sv
module pix_sig_capture
  import pix_sig_pkg::*;
#(
  parameter int unsigned        LANE_W = LANE_W_DEF,
  parameter logic [LANE_W-1:0]  TAPS   = TAPS_DEF,
  localparam int unsigned       LANES  = 2,
  localparam int unsigned       PIX_W  = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  input  logic              vblank_i,
  input  logic              vga_sel_i,
  input  logic              sig_en_i,
  input  logic              mask_en_i,
  input  logic              wide_i,
  input  logic [LANE_W-1:0] mask_hi_i,
  input  logic [LANE_W-1:0] mask_lo_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LANE_W-1:0] sig_o,
  output logic              sig_run_o
);
  logic [PIX_W-1:0] pix_c;
  logic             frame_start;

  pix_cond #(.LANE_W(LANE_W), .LANES(LANES)) u_cond (
    .pix_i     (pix_i),
    .mask_i    ({mask_hi_i, mask_lo_i}),
    .vga_sel_i (vga_sel_i),
    .mask_en_i (mask_en_i),
    .wide_i    (wide_i),
    .pix_o     (pix_c)
  );

  frame_edge u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vblank_i      (vblank_i),
    .frame_start_o (frame_start)
  );

  misr_core #(.W(LANE_W), .LANES(LANES), .TAPS(TAPS)) u_misr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .en_i          (sig_en_i),
    .valid_i       (pix_valid_i),
    .data_i        (pix_c),
    .sig_o         (sig_o),
    .run_o         (sig_run_o)
  );

  assign pix_o = pix_c;
endmodule

// File: rtl/pix_sig_capture_chk.sv
module pix_sig_capture_chk #(
  parameter int unsigned LANE_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*LANE_W-1:0] pix_i,
  input logic                pix_valid_i,
  input logic                vblank_i,
  input logic                vga_sel_i,
  input logic                sig_en_i,
  input logic                wide_i,
  input logic [2*LANE_W-1:0] pix_o,
  input logic [LANE_W-1:0]   sig_o,
  input logic                sig_run_o
);
  logic vb_q, edge_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end
  assign edge_c = vb_q & ~vblank_i;

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (sig_o == '0 && !sig_run_o); // R1
    end
  end

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vga_sel_i && !wide_i) |-> (pix_o[2*LANE_W-1:LANE_W] == '0)); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vga_sel_i |-> (pix_o == pix_i)); // R5

  AST_RUN_ONLY_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_c |=> $stable(sig_run_o)); // R6

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_c && sig_en_i && !sig_run_o && !pix_valid_i) |=> (sig_o == '0)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_valid_i && !(edge_c && sig_en_i && !sig_run_o)) |=> $stable(sig_o)); // R8

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sig_run_o && !(edge_c && sig_en_i)) |=> $stable(sig_o)); // R9

  AST_RUN_TRACKS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_c |=> (sig_run_o == $past(sig_en_i))); // R10
endmodule

bind pix_sig_capture pix_sig_capture_chk #(.LANE_W(LANE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_i       (pix_i),
  .pix_valid_i (pix_valid_i),
  .vblank_i    (vblank_i),
  .vga_sel_i   (vga_sel_i),
  .sig_en_i    (sig_en_i),
  .wide_i      (wide_i),
  .pix_o       (pix_o),
  .sig_o       (sig_o),
  .sig_run_o   (sig_run_o)
);

// File: tb/pix_sig_capture_test.sv
`timescale 1ns/1ps
module pix_sig_capture_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] pix = '0;
  logic        valid = 0, vblank = 0, vga = 0, en = 0, msk = 0, wide = 0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [63:0] pix_o;
  logic [31:0] sig_o;
  logic        run_o;

  int checks = 0, errors = 0;
  string cur_tag = "R8";

  always #4 clk = ~clk;

  pix_sig_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(valid),
    .vblank_i(vblank), .vga_sel_i(vga), .sig_en_i(en), .mask_en_i(msk),
    .wide_i(wide), .mask_hi_i(m_hi), .mask_lo_i(m_lo),
    .pix_o(pix_o), .sig_o(sig_o), .sig_run_o(run_o)
  );

  function automatic logic [63:0] ref_cond(input logic [63:0] p);
    logic [63:0] r;
    logic [63:0] m;
    m = {m_hi, m_lo};
    for (int i = 0; i < 64; i++) begin
      if (vga)                  r[i] = p[i];
      else if (i >= 32 && !wide) r[i] = 1'b0;
      else if (msk)             r[i] = p[i] & m[i];
      else                      r[i] = p[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [63:0] p);
    logic [31:0] t;
    t = s << 1;
    if (s[31]) t = t ^ 32'h0040_0007;
    return t ^ p[31:0] ^ p[63:32];
  endfunction

  // reference model
  logic [31:0] m_sig;
  logic        m_run, m_vb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sig <= '0; m_run <= 0; m_vb <= 0;
    end else begin
      logic        fs, nrun;
      logic [31:0] b;
      fs   = m_vb && !vblank;
      nrun = fs ? en : m_run;
      b    = (fs && en && !m_run) ? 32'h0 : m_sig;
      if (nrun && valid) b = ref_step(b, ref_cond(pix));
      m_sig <= b;
      m_run <= nrun;
      m_vb  <= vblank;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic vb);
    @(negedge clk);
    check(cur_tag, {32'h0, sig_o}, {32'h0, m_sig});
    check("R10", {63'h0, run_o}, {63'h0, m_run});
    valid  = v;
    vblank = vb;
    pix    = {$urandom, $urandom};
    #1;
    check(vga ? "R5" : msk ? "R4" : wide ? "R3" : "R2", pix_o, ref_cond(pix));
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) cycle(($urandom % 4) != 0, 1'b0);
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'h0, run_o, sig_o}, 64'h0);
    rst_n = 1;

    // conditioning combos
    m_hi = 32'hF0F0_A5A5; m_lo = 32'h0FF0_3C3C;
    for (int c = 0; c < 8; c++) begin
      vga = c[2]; msk = c[1]; wide = c[0];
      for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0);
    end
    vga = 0; msk = 1; wide = 1;

    // enable mid-frame: no effect until edge
    cur_tag = "R6";
    en = 1;
    frame(10);
    blank(3);
    // start edge, then accumulate
    cur_tag = "R7";
    cycle(1'b1, 1'b0);
    cur_tag = "R8";
    frame(40);
    blank(2);
    // keep running across boundary
    cur_tag = "R11";
    frame(30);
    wide = 0;
    frame(20);
    msk = 0;
    frame(20);
    // drop enable mid-frame
    cur_tag = "R9";
    en = 0;
    frame(20);
    blank(2);
    frame(30);
    blank(2);
    frame(10);
    // restart with 32-bit masked mode, pixel on edge cycle
    cur_tag = "R7";
    en = 1; msk = 1; wide = 0;
    blank(2);
    cycle(1'b1, 1'b0);
    cur_tag = "R8";
    frame(50);
    vga = 1;
    frame(20);
    blank(1);
    frame(1);
    @(negedge clk);
    check("R8", {32'h0, sig_o}, {32'h0, m_sig});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule